// File: doc/BRIEF.md
# Interrupt Request to Priority Level Mapper

This block takes eight level-sensitive interrupt request lines and turns them into a sixteen-line processor priority-level vector. Each request line is tied by a fixed, sparse table to one priority level; two of the request lines are tied to level 0 and are therefore dead inputs. The current state of the usable request lines is held in a pending register. The output vector has one line raised for every level that at least one pending request maps to.

A byte-wide control register sits on a simple register write port and is always visible on a read-data port. Bit 0 of that register is a global enable. Clearing it forces every priority line low but leaves the pending register untouched. Bit 6 can never be stored as one. The outputs are registered. They follow a request change or a control write one clock later and otherwise hold their value. Consumers pick the highest raised line themselves.

Top module: `irq_level_mapper`

## Requirements
- R1: Request bits map to priority lines as follows: bit 1 to line 1, bit 2 to line 4, bit 3 to line 6, bit 4 to line 8, bit 5 to line 10 and bit 7 to line 14.
- R2: Request bits 0 and 6 map to level 0 and are ignored. They never set a pending bit and never change any output.
- R3: Pending bits are level-sensitive. A pending bit is one while its usable request line is high and zero while it is low. `pend_o` bit n mirrors request bit n.
- R4: A control write is accepted only when `reg_wr_size` is 2'b00 (one byte). The codes 2'b01 (two bytes), 2'b10 (four bytes) and 2'b11 leave the register unchanged. `reg_rdata` always shows the stored control value.
- R5: An accepted write stores the written byte ANDed with 0xBF, so bit 6 always reads back as zero.
- R6: A synchronous reset sets the control register to 0x01 and clears the pending register and every priority line.
- R7: When control bit 0 is zero, all priority lines are low and pending bits are kept. Setting the bit again restores the lines of the still-pending requests.
- R8: Pending requests that map to different levels raise all their lines at the same time. The output is the OR of the one-hot level of every pending request.
- R9: Priority lines and pending bits change on the first clock edge after the request change or control write that causes them. Between such events they hold their value.
- R10: Priority line 0 is never driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Level-sensitive interrupt request lines |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_size | input | 2 | Access size code of the write (2'b00 = one byte) |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Stored control register value |
| pend_o | output | 8 | Pending register |
| pil_out | output | 16 | Registered priority-level lines |

## Verification
The assertions assume that the request lines and write controls are stable and known at each rising edge. They also assume that reset is held for at least one edge before checking starts, because every property is masked while reset is high. The bench changes all inputs only on falling edges and holds reset over several edges at start-up and in the mid-run reset test. Since the requests are treated as levels, the stimulus holds each request pattern for a full clock period, so no pulse shorter than one period can slip between edges.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int REQ_N  = 8;
  localparam int LVL_N  = 16;
  localparam int CTRL_W = 8;

  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hBF;
  localparam int                EN_BIT    = 0;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_RSVD  = 2'b11
  } acc_size_e;

  // Fixed request-bit to priority-level table; level 0 marks a dead input.
  function automatic int lvl_of(input int bit_idx);
    case (bit_idx)
      1:       return 1;
      2:       return 4;
      3:       return 6;
      4:       return 8;
      5:       return 10;
      7:       return 14;
      default: return 0;
    endcase
  endfunction

  // Request bits that feed a given level.
  function automatic logic [REQ_N-1:0] hit_mask(input int lvl);
    logic [REQ_N-1:0] m;
    m = '0;
    for (int b = 0; b < REQ_N; b++)
      if (lvl != 0 && lvl_of(b) == lvl) m[b] = 1'b1;
    return m;
  endfunction

  // Request bits that map to a non-zero level.
  function automatic logic [REQ_N-1:0] live_mask();
    logic [REQ_N-1:0] m;
    m = '0;
    for (int b = 0; b < REQ_N; b++)
      if (lvl_of(b) != 0) m[b] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqmap_ctrl.sv
module irqmap_ctrl
  import irqmap_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_size,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic         en_nxt
);

  logic         wr_ok;
  logic [W-1:0] ctrl_nxt;

  assign wr_ok    = wr_en && (acc_size_e'(wr_size) == SZ_BYTE);
  assign ctrl_nxt = wr_ok ? (wdata & CTRL_MASK) : ctrl_q;
  assign en_nxt   = ctrl_nxt[EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RST;
    else     ctrl_q <= ctrl_nxt;
  end

  // R5
  ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> ctrl_q == ($past(wdata) & CTRL_MASK));

  // R4
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> $stable(ctrl_q));

endmodule

// File: rtl/irqmap_pending.sv
module irqmap_pending
  import irqmap_pkg::*;
#(
  parameter int N = REQ_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] pend_nxt,
  output logic [N-1:0] pend_q
);

  localparam logic [N-1:0] LIVE = live_mask();

  assign pend_nxt = req & LIVE;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  // R3
  pend_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((req & LIVE) != pend_q) |=> !$stable(pend_q));

  // R2
  pend_dead_chk: assert property (@(posedge clk) disable iff (rst)
    ((req & LIVE) == pend_q) |=> $stable(pend_q));

endmodule

// File: rtl/irqmap_decode.sv
module irqmap_decode
  import irqmap_pkg::*;
#(
  parameter int N = REQ_N,
  parameter int L = LVL_N
) (
  input  logic [N-1:0] pend,
  output logic [L-1:0] lvl_vec
);

  for (genvar l = 0; l < L; l++) begin : g_lvl
    localparam logic [N-1:0] HIT = hit_mask(l);
    assign lvl_vec[l] = |(pend & HIT);
  end

endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irqmap_pkg::*;
#(
  parameter int N = REQ_N,
  parameter int L = LVL_N,
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_req,
  input  logic         reg_wr_en,
  input  logic [1:0]   reg_wr_size,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [N-1:0] pend_o,
  output logic [L-1:0] pil_out
);

  logic [W-1:0] ctrl_q;
  logic         en_nxt;
  logic [N-1:0] pend_nxt;
  logic [N-1:0] pend_q;
  logic [L-1:0] lvl_vec;
  logic [L-1:0] pil_q;

  irqmap_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_size (reg_wr_size),
    .wdata   (reg_wdata),
    .ctrl_q  (ctrl_q),
    .en_nxt  (en_nxt)
  );

  irqmap_pending #(.N(N)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .req      (irq_req),
    .pend_nxt (pend_nxt),
    .pend_q   (pend_q)
  );

  irqmap_decode #(.N(N), .L(L)) u_dec (
    .pend    (pend_nxt),
    .lvl_vec (lvl_vec)
  );

  // Output stage looks at next-state values so it lands on the same edge.
  always_ff @(posedge clk) begin
    if (rst)         pil_q <= '0;
    else if (en_nxt) pil_q <= lvl_vec;
    else             pil_q <= '0;
  end

  assign reg_rdata = ctrl_q;
  assign pend_o    = pend_q;
  assign pil_out   = pil_q;

  // R10
  lvl0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pil_q[0] == 1'b0);

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[EN_BIT] |-> pil_q == '0);

  // R8
  lines_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pil_q) <= $countones(pend_q));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_nxt == pend_q) && (en_nxt == ctrl_q[EN_BIT]) |=> $stable(pil_q));

endmodule

// File: tb/test_irq_level_mapper.sv
module test_irq_level_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_req = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_size = 2'b00;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  pend_o;
  logic [15:0] pil_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_level_mapper i_irq_level_mapper (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_size (reg_wr_size),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .pend_o      (pend_o),
    .pil_out     (pil_out)
  );

  // {request, expected lines, expected pending}
  localparam logic [31:0] VEC [12] = '{
    {8'h00, 16'h0000, 8'h00},
    {8'h02, 16'h0002, 8'h02},
    {8'h04, 16'h0010, 8'h04},
    {8'h08, 16'h0040, 8'h08},
    {8'h10, 16'h0100, 8'h10},
    {8'h20, 16'h0400, 8'h20},
    {8'h80, 16'h4000, 8'h80},
    {8'h01, 16'h0000, 8'h00},
    {8'h40, 16'h0000, 8'h00},
    {8'hFF, 16'h4552, 8'hBE},
    {8'hA5, 16'h4410, 8'hA4},
    {8'h41, 16'h0000, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [1:0] sz);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = d; reg_wr_size = sz;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 ctrl", {24'h0, reg_rdata}, 32'h01);
    chk("R6 pend", {24'h0, pend_o}, 32'h0);
    chk("R6 lines", {16'h0, pil_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R8 table walk
    for (int i = 0; i < 12; i++) begin
      irq_req = VEC[i][31:24];
      @(negedge clk);
      chk("R1/R8 lines", {16'h0, pil_out}, {16'h0, VEC[i][23:8]});
      chk("R2/R3 pend", {24'h0, pend_o}, {24'h0, VEC[i][7:0]});
      chk("R10 line0", {31'h0, pil_out[0]}, 32'h0);
    end

    // R9 update lands one edge later
    irq_req = 8'h00;
    @(negedge clk);
    irq_req = 8'h20;
    #2 chk("R9 before edge", {16'h0, pil_out}, 32'h0);
    @(negedge clk);
    chk("R9 after edge", {16'h0, pil_out}, 32'h0400);
    @(negedge clk);
    chk("R9 held", {16'h0, pil_out}, 32'h0400);

    // R2 toggling dead inputs changes nothing
    irq_req = 8'h61;
    @(negedge clk);
    chk("R2 dead lines", {16'h0, pil_out}, 32'h0400);
    chk("R2 dead pend", {24'h0, pend_o}, 32'h20);

    // R5 mask and R4 byte write
    wr(8'hFF, 2'b00);
    chk("R5 mask", {24'h0, reg_rdata}, 32'hBF);
    // R4 non-byte sizes ignored
    wr(8'h00, 2'b10);
    chk("R4 word ignored", {24'h0, reg_rdata}, 32'hBF);
    wr(8'h00, 2'b01);
    chk("R4 half ignored", {24'h0, reg_rdata}, 32'hBF);

    // R7 disable keeps pending
    irq_req = 8'hFF;
    @(negedge clk);
    chk("R8 all lines", {16'h0, pil_out}, 32'h4552);
    wr(8'h00, 2'b00);
    chk("R7 off lines", {16'h0, pil_out}, 32'h0);
    chk("R7 off pend", {24'h0, pend_o}, 32'hBE);
    irq_req = 8'h84;
    @(negedge clk);
    chk("R7 off follow pend", {24'h0, pend_o}, 32'h84);
    chk("R7 off still low", {16'h0, pil_out}, 32'h0);
    wr(8'h01, 2'b00);
    chk("R7 reenable", {16'h0, pil_out}, 32'h4010);

    // R6 mid-run reset
    wr(8'h3C, 2'b00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 rerst ctrl", {24'h0, reg_rdata}, 32'h01);
    chk("R6 rerst lines", {16'h0, pil_out}, 32'h0);
    chk("R6 rerst pend", {24'h0, pend_o}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 after reset", {24'h0, pend_o}, 32'h84);
    summary();
  end

endmodule